// File: doc/BRIEF.md
# Addressed SPI Slave Interface

This block is a serial peripheral slave with an active-low select line and an 8-bit shift path. The serial clock comes only from the remote master. The block samples SCK, MOSI and the select line with its own faster system clock, so there is no baud-rate setting at all. Either clock polarity and either clock phase can be chosen, which gives all four SPI transfer modes. Data is shifted most significant bit first.

A small host register port lets the local side work with the block. One data offset serves both directions: a write stages the next transmit byte and a read returns the last received byte. Other registers hold the configuration, the two address operands, the event flags, the interrupt enables and a sticky overflow status. When addressed framing is enabled, the first byte of each select period is compared with the address operands in one of three ways: masked equality, either of two exact values, or an inclusive range. A frame that fails the comparison is dropped as a whole. Its remaining bytes are not stored, and the data line is released until select goes high again.

Register offsets: 0 DATA, 1 CFG, 2 ADDR_VAL, 3 ADDR_AUX, 4 FLAGS, 5 IRQ_EN, 6 STATUS. Reads are combinational from `reg_addr`, and writes take effect at the clock edge where `reg_wr` is high.

Top module: `spi_addr_slave`

## Requirements
- R1: CFG bit 0 selects the idle level of SCK and CFG bit 1 selects the phase (0: sample on the leading edge, 1: sample on the trailing edge). In all four modes, bytes move MSB first in both directions.
- R2: After reset, FLAGS reads 0x01, STATUS reads 0x00, `miso_oe` is low and `irq` is low.
- R3: A write to DATA stages a transmit byte and clears FLAGS bit 0 (empty). FLAGS bit 0 is set again when the staged byte moves into the shifter. If nothing new was written, the shifter sends the last written byte, or 0x00 after reset.
- R4: Each accepted received byte becomes readable at DATA and sets FLAGS bit 1. A read of DATA (a cycle with `reg_rd` high at offset 0) clears FLAGS bit 1.
- R5: FLAGS bit 2 is set when select falls and FLAGS bit 3 is set when select rises. Writing 1 to FLAGS bits 2, 3 or 4 clears those bits.
- R6: If a byte completes while FLAGS bit 1 is still set, STATUS bit 0 and FLAGS bit 4 are set and the held byte is kept. Writing 1 to STATUS bit 0 clears it.
- R7: CFG bit 2 enables addressed framing. Only the first byte after select falls is compared. A byte that matches is stored as received data, and later bytes in the same frame are delivered without comparison.
- R8: With CFG[4:3]=0 (mask mode), a byte matches when it equals ADDR_VAL at every bit position where ADDR_AUX holds 0.
- R9: With CFG[4:3]=1 (pair mode), a byte matches when it equals ADDR_VAL or ADDR_AUX.
- R10: With CFG[4:3]=2 (range mode), a byte matches when ADDR_AUX <= byte <= ADDR_VAL, both ends included. CFG[4:3]=3 never matches.
- R11: After an address mismatch, the rest of the frame is ignored: FLAGS bit 1 does not set, no overflow is recorded, and `miso_oe` stays low until select rises.
- R12: `irq` is high exactly when some FLAGS bit and the matching IRQ_EN (offset 5) bit are both set.
- R13: `miso_oe` is high only while select is active and the frame has not been rejected. It is low while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (side effects on DATA) |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for miso_o |

## Verification
Every serial input passes through a two-flop synchronizer and then an edge register, so the block reacts to a SCK or select edge about three system cycles after it. A flag or DATA update lands one cycle later. The bench holds each SCK level for ten system cycles and waits twenty cycles after each select change, so every byte, flag and `miso_oe` value has settled before it is read. Register writes take effect at the next edge and reads are sampled one nanosecond after a falling clock edge.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
  localparam int DW    = 8;
  localparam int RAW   = 3;
  localparam int NFLAG = 5;

  // address comparison flavours
  typedef enum logic [1:0] {
    AM_MASK  = 2'd0,
    AM_PAIR  = 2'd1,
    AM_RANGE = 2'd2,
    AM_NONE  = 2'd3
  } amode_e;

  // configuration word, LSB = cpol
  typedef struct packed {
    amode_e amode;
    logic   addr_en;
    logic   cpha;
    logic   cpol;
  } cfg_t;

  localparam int CFGW = 5;

  localparam logic [RAW-1:0] OFS_DATA  = 3'd0;
  localparam logic [RAW-1:0] OFS_CFG   = 3'd1;
  localparam logic [RAW-1:0] OFS_AVAL  = 3'd2;
  localparam logic [RAW-1:0] OFS_AAUX  = 3'd3;
  localparam logic [RAW-1:0] OFS_FLAGS = 3'd4;
  localparam logic [RAW-1:0] OFS_IEN   = 3'd5;
  localparam logic [RAW-1:0] OFS_STAT  = 3'd6;

  localparam int FL_DRE = 0;
  localparam int FL_RXC = 1;
  localparam int FL_SSL = 2;
  localparam int FL_TXC = 3;
  localparam int FL_ERR = 4;
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_addr_match.sv
`timescale 1ns/1ps
module spi_addr_match
  import spi_slv_pkg::*;
#(
  parameter int DW = spi_slv_pkg::DW
) (
  input  amode_e        mode,
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] aux,
  output logic          hit
);
  always_comb begin
    case (mode)
      AM_MASK:  hit = (((rx ^ val) & ~aux) == '0);
      AM_PAIR:  hit = (rx == val) || (rx == aux);
      AM_RANGE: hit = (rx >= aux) && (rx <= val);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
  parameter int DW = spi_slv_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          addr_en,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          ss_act,
  input  logic [DW-1:0] tx_hold,
  input  logic          addr_hit,
  output logic [DW-1:0] cur_byte,
  output logic          tx_load,
  output logic          deliver_stb,
  output logic          ss_fall,
  output logic          ss_rise,
  output logic          miso_o,
  output logic          miso_oe
);
  localparam int           CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sck_q, act_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          first_q, first_n;
  logic          drop_q, drop_n;
  logic [DW-1:0] rx_q, rx_n;
  logic [DW-1:0] tx_q, tx_n;

  logic lead, trail, smp, shf;

  always_comb begin
    lead    = cpol ? (sck_q & ~sck_s) : (~sck_q & sck_s);
    trail   = cpol ? (~sck_q & sck_s) : (sck_q & ~sck_s);
    smp     = ss_act & (cpha ? trail : lead);
    shf     = ss_act & (cpha ? lead : trail);
    ss_fall = ss_act & ~act_q;
    ss_rise = ~ss_act & act_q;
  end

  assign cur_byte = {rx_q[DW-2:0], mosi_s};

  // next-state logic
  always_comb begin
    cnt_n       = cnt_q;
    first_n     = first_q;
    drop_n      = drop_q;
    rx_n        = rx_q;
    tx_n        = tx_q;
    tx_load     = 1'b0;
    deliver_stb = 1'b0;
    if (ss_fall) begin
      cnt_n   = '0;
      first_n = 1'b1;
      drop_n  = 1'b0;
      if (!cpha) begin
        tx_n    = tx_hold;
        tx_load = 1'b1;
      end
    end else if (ss_rise) begin
      cnt_n   = '0;
      first_n = 1'b1;
      drop_n  = 1'b0;
    end else begin
      if (smp && !drop_q) begin
        rx_n = cur_byte;
        if (cnt_q == LAST) begin
          cnt_n   = '0;
          first_n = 1'b0;
          if (first_q && addr_en && !addr_hit) drop_n = 1'b1;
          else                                 deliver_stb = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (shf && !drop_q) begin
        if (cnt_q == '0) begin
          tx_n    = tx_hold;
          tx_load = 1'b1;
        end else begin
          tx_n = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b1;
      drop_q  <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else begin
      sck_q   <= sck_s;
      act_q   <= ss_act;
      cnt_q   <= cnt_n;
      first_q <= first_n;
      drop_q  <= drop_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
    end
  end

  assign miso_o  = tx_q[DW-1];
  assign miso_oe = ss_act & ~drop_q;
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank
  import spi_slv_pkg::*;
#(
  parameter int DW  = spi_slv_pkg::DW,
  parameter int RAW = spi_slv_pkg::RAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             tx_load,
  input  logic             deliver_stb,
  input  logic [DW-1:0]    deliver_byte,
  input  logic             ss_fall,
  input  logic             ss_rise,
  output cfg_t             cfg,
  output logic [DW-1:0]    addr_val,
  output logic [DW-1:0]    addr_aux,
  output logic [DW-1:0]    tx_hold,
  output logic [NFLAG-1:0] flags,
  output logic             ovf,
  output logic             irq
);
  cfg_t             cfg_q, cfg_n;
  logic [DW-1:0]    aval_q, aval_n, aaux_q, aaux_n;
  logic [NFLAG-1:0] ien_q, ien_n;
  logic [DW-1:0]    hold_q, hold_n;
  logic             full_q, full_n;
  logic [DW-1:0]    rxd_q, rxd_n;
  logic             rxv_q, rxv_n;
  logic             ssl_q, ssl_n, txc_q, txc_n, err_q, err_n;
  logic             ovf_q, ovf_n;
  logic             wr_data, rd_data, wr_flags, wr_stat;

  always_comb begin
    wr_data  = reg_wr && (reg_addr == OFS_DATA);
    rd_data  = reg_rd && (reg_addr == OFS_DATA);
    wr_flags = reg_wr && (reg_addr == OFS_FLAGS);
    wr_stat  = reg_wr && (reg_addr == OFS_STAT);

    cfg_n  = cfg_q;
    aval_n = aval_q;
    aaux_n = aaux_q;
    ien_n  = ien_q;
    if (reg_wr && reg_addr == OFS_CFG)  cfg_n  = cfg_t'(reg_wdata[CFGW-1:0]);
    if (reg_wr && reg_addr == OFS_AVAL) aval_n = reg_wdata;
    if (reg_wr && reg_addr == OFS_AAUX) aaux_n = reg_wdata;
    if (reg_wr && reg_addr == OFS_IEN)  ien_n  = reg_wdata[NFLAG-1:0];

    // transmit staging: host write wins over a same-cycle load
    hold_n = hold_q;
    full_n = full_q;
    if (tx_load) full_n = 1'b0;
    if (wr_data) begin
      hold_n = reg_wdata;
      full_n = 1'b1;
    end

    // receive holding and overflow
    rxd_n = rxd_q;
    rxv_n = rxv_q & ~rd_data;
    ovf_n = ovf_q;
    err_n = err_q;
    ssl_n = ssl_q;
    txc_n = txc_q;
    if (wr_flags && reg_wdata[FL_SSL]) ssl_n = 1'b0;
    if (wr_flags && reg_wdata[FL_TXC]) txc_n = 1'b0;
    if (wr_flags && reg_wdata[FL_ERR]) err_n = 1'b0;
    if (wr_stat && reg_wdata[0])       ovf_n = 1'b0;
    if (deliver_stb) begin
      if (rxv_n) begin
        ovf_n = 1'b1;
        err_n = 1'b1;
      end else begin
        rxd_n = deliver_byte;
        rxv_n = 1'b1;
      end
    end
    if (ss_fall) ssl_n = 1'b1;
    if (ss_rise) txc_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      aval_q <= '0;
      aaux_q <= '0;
      ien_q  <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      rxd_q  <= '0;
      rxv_q  <= 1'b0;
      ssl_q  <= 1'b0;
      txc_q  <= 1'b0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      aval_q <= aval_n;
      aaux_q <= aaux_n;
      ien_q  <= ien_n;
      hold_q <= hold_n;
      full_q <= full_n;
      rxd_q  <= rxd_n;
      rxv_q  <= rxv_n;
      ssl_q  <= ssl_n;
      txc_q  <= txc_n;
      err_q  <= err_n;
      ovf_q  <= ovf_n;
    end
  end

  always_comb begin
    flags         = '0;
    flags[FL_DRE] = ~full_q;
    flags[FL_RXC] = rxv_q;
    flags[FL_SSL] = ssl_q;
    flags[FL_TXC] = txc_q;
    flags[FL_ERR] = err_q;
  end

  always_comb begin
    case (reg_addr)
      OFS_DATA:  reg_rdata = rxd_q;
      OFS_CFG:   reg_rdata = {{(DW-CFGW){1'b0}}, cfg_q};
      OFS_AVAL:  reg_rdata = aval_q;
      OFS_AAUX:  reg_rdata = aaux_q;
      OFS_FLAGS: reg_rdata = {{(DW-NFLAG){1'b0}}, flags};
      OFS_IEN:   reg_rdata = {{(DW-NFLAG){1'b0}}, ien_q};
      OFS_STAT:  reg_rdata = {{(DW-1){1'b0}}, ovf_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign cfg      = cfg_q;
  assign addr_val = aval_q;
  assign addr_aux = aaux_q;
  assign tx_hold  = hold_q;
  assign ovf      = ovf_q;
  assign irq      = |(flags & ien_q);
endmodule

// File: rtl/spi_addr_slave.sv
`timescale 1ns/1ps
module spi_addr_slave
  import spi_slv_pkg::*;
#(
  parameter int DW          = spi_slv_pkg::DW,
  parameter int RAW         = spi_slv_pkg::RAW,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  input  logic           sck_i,
  input  logic           mosi_i,
  input  logic           ss_n_i,
  output logic           miso_o,
  output logic           miso_oe
);
  logic             rst_n_s;
  logic [2:0]       pins_s;
  logic             ss_act;
  cfg_t             cfg_w;
  logic [DW-1:0]    aval_w, aaux_w, hold_w, cur_byte;
  logic             addr_hit, tx_load, deliver_stb, ss_fall, ss_rise;
  logic [NFLAG-1:0] flags_w;
  logic             ovf_w;

  spi_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_n_s), .d({ss_n_i, mosi_i, sck_i}), .q(pins_s)
  );

  assign ss_act = ~pins_s[2];

  spi_addr_match #(.DW(DW)) u_match (
    .mode(cfg_w.amode), .rx(cur_byte), .val(aval_w), .aux(aaux_w), .hit(addr_hit)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n_s),
    .cpol(cfg_w.cpol), .cpha(cfg_w.cpha), .addr_en(cfg_w.addr_en),
    .sck_s(pins_s[0]), .mosi_s(pins_s[1]), .ss_act(ss_act),
    .tx_hold(hold_w), .addr_hit(addr_hit), .cur_byte(cur_byte),
    .tx_load(tx_load), .deliver_stb(deliver_stb),
    .ss_fall(ss_fall), .ss_rise(ss_rise),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  spi_reg_bank #(.DW(DW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_load(tx_load), .deliver_stb(deliver_stb), .deliver_byte(cur_byte),
    .ss_fall(ss_fall), .ss_rise(ss_rise),
    .cfg(cfg_w), .addr_val(aval_w), .addr_aux(aaux_w), .tx_hold(hold_w),
    .flags(flags_w), .ovf(ovf_w), .irq(irq)
  );
endmodule

// File: rtl/spi_addr_slave_chk.sv
`timescale 1ns/1ps
module spi_addr_slave_chk
  import spi_slv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [RAW-1:0]   reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [NFLAG-1:0] flags,
  input logic             ovf,
  input logic             deliver_stb,
  input logic             ss_fall,
  input logic             ss_act,
  input logic             miso_oe
);
  a_r3_empty_clears_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DATA) |=> !flags[FL_DRE]);

  a_r4_rx_flag_clears_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_DATA && !deliver_stb) |=> !flags[FL_RXC]);

  a_r4_delivery_sets_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_stb |=> flags[FL_RXC]);

  a_r5_select_fall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ss_fall |=> flags[FL_SSL]);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(reg_wr && reg_addr == OFS_STAT && reg_wdata[0])) |=> ovf);

  a_r13_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> ss_act);
endmodule

bind spi_addr_slave spi_addr_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n_s),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .flags(flags_w), .ovf(ovf_w), .deliver_stb(deliver_stb),
  .ss_fall(ss_fall), .ss_act(ss_act), .miso_oe(miso_oe)
);

// File: tb/spi_addr_slave_test.sv
`timescale 1ns/1ps
module spi_addr_slave_test;
  localparam int HALF = 10;

  logic       clk, rst_n;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, sck, mosi, ss_n, miso_o, miso_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic cpol = 0, cpha = 0;
  logic [7:0] model_tx = 8'h00;
  logic [7:0] exp_miso[$];
  logic [7:0] got_miso;
  string      miso_tag;
  event       miso_ev;

  spi_addr_slave uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_i(sck), .mosi_i(mosi), .ss_n_i(ss_n),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: compares each byte seen on MISO with the scoreboard head
  always @(miso_ev) begin
    if (exp_miso.size() == 0) chk({miso_tag, " unexpected miso byte"}, got_miso, 8'hxx);
    else chk({miso_tag, " miso"}, got_miso, exp_miso.pop_front());
  end

  task automatic nap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    if (a == 3'd0) model_tx = d;
    if (a == 3'd1) begin cpol = d[0]; cpha = d[1]; end
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    host_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic spi_byte(input logic [7:0] dout, output logic [7:0] din);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi = dout[i]; nap(HALF);
        din[i] = miso_o; sck = ~cpol; nap(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = dout[i]; nap(HALF);
        din[i] = miso_o; sck = cpol; nap(HALF);
      end
    end
  endtask

  // driver: pushes expected MISO bytes, then shifts the frame
  task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input bit acc, input string tag);
    logic [7:0] got;
    sck = cpol; nap(4);
    ss_n = 0; nap(2*HALF);
    for (int k = 0; k < n; k++) begin
      if (k == 0 || acc) exp_miso.push_back(model_tx);
      spi_byte((k == 0) ? b0 : b1, got);
      if (k == 0 || acc) begin
        got_miso = got; miso_tag = tag; ->miso_ev;
      end
    end
    nap(HALF);
    chk({tag, " R11 R13 drive enable at frame end"}, {7'd0, miso_oe}, {7'd0, acc});
    ss_n = 1; nap(2*HALF);
    chk({tag, " R13 drive enable after deselect"}, {7'd0, miso_oe}, 8'h00);
  endtask

  task automatic addr_case(input logic [7:0] b, input bit acc, input string tag);
    frame(1, b, 8'h00, acc, tag);
    if (acc) rd_chk({tag, " accepted address byte stored"}, 3'd0, b);
    rd_chk({tag, " rx flag state"}, 3'd4, 8'h0D);
    host_wr(3'd4, 8'h1C);
  endtask

  initial begin
    logic [7:0] txv [4];
    logic [7:0] rxv [4];
    txv = '{8'hC3, 8'h81, 8'h7E, 8'h18};
    rxv = '{8'h5A, 8'h3C, 8'hE1, 8'h96};
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    sck = 0; mosi = 0; ss_n = 1;
    nap(5); rst_n = 1; nap(10);

    // R2 reset state
    rd_chk("R2 flags after reset", 3'd4, 8'h01);
    rd_chk("R2 status after reset", 3'd6, 8'h00);
    chk("R2 miso_oe after reset", {7'd0, miso_oe}, 8'h00);
    chk("R2 irq after reset", {7'd0, irq}, 8'h00);

    // R3 zero shifted before any write; R4/R5 flags
    frame(1, 8'hA5, 8'h00, 1, "R3 reset tx zero");
    rd_chk("R4 R5 flags after first frame", 3'd4, 8'h0F);
    rd_chk("R4 received byte", 3'd0, 8'hA5);
    rd_chk("R4 rx flag cleared by read", 3'd4, 8'h0D);
    host_wr(3'd4, 8'h1C);
    rd_chk("R5 write-one clears event flags", 3'd4, 8'h01);

    // R1 all four modes
    for (int m = 0; m < 4; m++) begin
      host_wr(3'd1, 8'(m));
      host_wr(3'd0, txv[m]);
      rd_chk("R3 empty flag cleared by write", 3'd4, 8'h00);
      frame(1, rxv[m], 8'h00, 1, "R1 mode transfer");
      rd_chk("R1 R3 flags after mode frame", 3'd4, 8'h0F);
      rd_chk("R1 received byte in mode", 3'd0, rxv[m]);
      host_wr(3'd4, 8'h1C);
    end

    // R3 last written byte repeats
    frame(1, 8'h44, 8'h00, 1, "R3 repeat last byte");
    rd_chk("R3 repeat frame data", 3'd0, 8'h44);
    host_wr(3'd4, 8'h1C);

    // R6 overflow, R12 irq
    host_wr(3'd1, 8'h00);
    host_wr(3'd0, 8'h5B);
    frame(2, 8'h11, 8'h22, 1, "R6 two byte frame");
    rd_chk("R6 overflow status", 3'd6, 8'h01);
    rd_chk("R6 error flag", 3'd4, 8'h1F);
    host_wr(3'd5, 8'h10);
    chk("R12 irq from error flag", {7'd0, irq}, 8'h01);
    rd_chk("R6 held byte kept", 3'd0, 8'h11);
    host_wr(3'd6, 8'h01);
    rd_chk("R6 status cleared", 3'd6, 8'h00);
    host_wr(3'd4, 8'h1C);
    chk("R12 irq drops with flag", {7'd0, irq}, 8'h00);
    host_wr(3'd5, 8'h01);
    chk("R12 irq from empty flag", {7'd0, irq}, 8'h01);
    host_wr(3'd5, 8'h02);
    chk("R12 irq masked", {7'd0, irq}, 8'h00);
    host_wr(3'd5, 8'h00);

    // R8 mask mode
    host_wr(3'd1, 8'h04);
    host_wr(3'd2, 8'h40);
    host_wr(3'd3, 8'h0F);
    addr_case(8'h4A, 1, "R8 mask match");
    frame(2, 8'h5A, 8'h40, 0, "R11 mask reject");
    rd_chk("R11 no rx flag after reject", 3'd4, 8'h0D);
    rd_chk("R11 no overflow after reject", 3'd6, 8'h00);
    host_wr(3'd4, 8'h1C);
    // R7 only first byte compared
    frame(2, 8'h43, 8'h99, 1, "R7 second byte unfiltered");
    rd_chk("R7 second byte delivered (overflow)", 3'd6, 8'h01);
    rd_chk("R7 first byte stored", 3'd0, 8'h43);
    host_wr(3'd6, 8'h01);
    host_wr(3'd4, 8'h1C);

    // R9 pair mode
    host_wr(3'd1, 8'h0C);
    host_wr(3'd2, 8'h21);
    host_wr(3'd3, 8'h63);
    addr_case(8'h63, 1, "R9 pair aux");
    addr_case(8'h21, 1, "R9 pair val");
    addr_case(8'h22, 0, "R9 pair miss");

    // R10 range and reserved mode
    host_wr(3'd1, 8'h14);
    host_wr(3'd2, 8'h07);
    host_wr(3'd3, 8'h01);
    addr_case(8'h01, 1, "R10 range low");
    addr_case(8'h07, 1, "R10 range high");
    addr_case(8'h08, 0, "R10 range above");
    addr_case(8'h00, 0, "R10 range below");
    host_wr(3'd1, 8'h1C);
    addr_case(8'h01, 0, "R10 reserved mode");

    chk("R3 scoreboard drained", 8'(exp_miso.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule